// File: doc/BRIEF.md
# Word-to-Byte Register Bus Bridge

This block is a slave on a 32-bit Wishbone bus. Behind it sits a bank of 32 eight-bit configuration registers. Each accepted bus cycle is split into four single-byte operations, done one per clock. A decoder turns each byte offset into a register index. On a read, the bridge collects the four bytes into one word. On a write, it spreads the word out to the selected registers.

The master waits in a stall until the fourth byte has been handled. The bridge then raises a one-cycle acknowledge. A master uses it like any memory-mapped word slave that is a little slow. Software sees a word view of registers that are really stored one byte each.

Top module: `wb_byte_bridge`

## Requirements
- R1: An access starts only when cyc and stb are both high and address bits 31:24 equal 0x26. Any other address never gets an acknowledge.
- R2: The acknowledge appears exactly five rising edges after the edge that samples the request: one edge to accept it and four byte steps. This holds for unmapped offsets too.
- R3: The acknowledge lasts one cycle. The bridge then goes idle and starts nothing until cyc and stb are presented again.
- R4: Byte lanes are little-endian. The byte at word offset +0 is on data bits 7:0, and the byte at +3 is on bits 31:24.
- R5: On a write, the register behind lane n changes only when select bit n is 1. Other registers keep their values.
- R6: A read returns all four lanes, whatever the select bits are.
- R7: The byte offset is address bits 23:0 plus the step number. Offsets 0 to 31 select register 0 to 31. Any larger offset reads as 0x00 and ignores writes.
- R8: Synchronous active-high reset loads register k with (k*37+5) mod 256. It also returns the sequencer to idle, which drops any access in progress without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Strobe for this slave |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_sel | input | 4 | Byte lane write enables |
| wb_adr | input | 32 | Byte address of the word |
| wb_wdat | input | 32 | Write data |
| wb_rdat | output | 32 | Read data, valid while wb_ack is high |
| wb_ack | output | 1 | One-cycle completion strobe |

## Verification
The request is driven on a falling edge, and the bench counts the rising edges after it. The acknowledge must be seen after the fifth edge, and read data is captured in that same cycle. One edge later the acknowledge must be low again. Write effects are checked with a later read, which has the same five-edge timing. This works because a byte update lands on the edge of its own step. Requests that must not be answered, and requests cut off by reset, are watched for at least ten edges with no acknowledge allowed.

// File: rtl/wb_byte_bridge.sv
module wb_byte_bridge #(
  parameter logic [31:0] BASE     = 32'h2600_0000,
  parameter int          WIN_BITS = 24,
  parameter int          NREGS    = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wb_cyc,
  input  logic        wb_stb,
  input  logic        wb_we,
  input  logic [3:0]  wb_sel,
  input  logic [31:0] wb_adr,
  input  logic [31:0] wb_wdat,
  output logic [31:0] wb_rdat,
  output logic        wb_ack
);
  localparam int IDXW = $clog2(NREGS);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_ACK} st_t;

  st_t                 st;
  logic [1:0]          step;
  logic [WIN_BITS-3:0] wadr;
  logic                we_q;
  logic [3:0]          sel_q;
  logic [31:0]         wd_q;
  logic [31:0]         rd_q;
  logic [7:0]          regs [NREGS];

  function automatic logic [7:0] rst_val(int k);
    return 8'((k * 37 + 5) % 256);
  endfunction

  wire                hit    = wb_adr[31:WIN_BITS] == BASE[31:WIN_BITS];
  wire                req    = wb_cyc && wb_stb && hit;
  wire [WIN_BITS-1:0] off    = {wadr, step};
  wire                mapped = off < WIN_BITS'(NREGS);
  wire [IDXW-1:0]     idx    = off[IDXW-1:0];
  wire [7:0]          cur    = mapped ? regs[idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      step  <= 2'd0;
      wadr  <= '0;
      we_q  <= 1'b0;
      sel_q <= 4'd0;
      wd_q  <= 32'd0;
      rd_q  <= 32'd0;
      for (int k = 0; k < NREGS; k++) regs[k] <= rst_val(k);
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st    <= S_BUSY;
          step  <= 2'd0;
          wadr  <= wb_adr[WIN_BITS-1:2];
          we_q  <= wb_we;
          sel_q <= wb_sel;
          wd_q  <= wb_wdat;
        end
        S_BUSY: begin
          rd_q[8*step +: 8] <= cur;
          if (we_q && sel_q[step] && mapped) regs[idx] <= wd_q[8*step +: 8];
          step <= step + 2'd1;
          if (step == 2'd3) st <= S_ACK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wb_ack  = st == S_ACK;
  assign wb_rdat = rd_q;

  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  // R2
  ack_after_last_step_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(st == S_BUSY && step == 2'd3));

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && step != 2'd3) |=> (st == S_BUSY && step == $past(step) + 2'd1));

  // R1
  outside_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !hit) |=> st != S_ACK && step == $past(step));

  // R3
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |=> !wb_ack);
endmodule

// File: tb/tb_wb_byte_bridge.sv
module tb_wb_byte_bridge;
  logic clk = 0, rst = 1;
  logic cyc = 0, stb = 0, we = 0;
  logic [3:0] sel = 0;
  logic [31:0] adr = 0, wdat = 0;
  logic [31:0] rdat;
  logic ack;
  int nchk = 0, nerr = 0;
  logic [7:0] mdl [32];

  localparam logic [31:0] BASE = 32'h2600_0000;

  always #4 clk = ~clk;

  wb_byte_bridge dut (.clk(clk), .rst(rst), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
    .wb_sel(sel), .wb_adr(adr), .wb_wdat(wdat), .wb_rdat(rdat), .wb_ack(ack));

  // {we, sel, offset, data}
  localparam int NV = 13;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 4'hF, 32'h0000_0000, 32'h1122_3344},
    {1'b0, 4'hF, 32'h0000_0000, 32'h0},
    {1'b1, 4'h5, 32'h0000_0004, 32'hAABB_CCDD},
    {1'b0, 4'h0, 32'h0000_0004, 32'h0},
    {1'b1, 4'hA, 32'h0000_001C, 32'h0102_0304},
    {1'b0, 4'h1, 32'h0000_001C, 32'h0},
    {1'b1, 4'hF, 32'h0000_0020, 32'hDEAD_BEEF},
    {1'b0, 4'hF, 32'h0000_0020, 32'h0},
    {1'b0, 4'h3, 32'h0000_0000, 32'h0},
    {1'b1, 4'h0, 32'h0000_0008, 32'hFFFF_FFFF},
    {1'b0, 4'hF, 32'h0000_0008, 32'h0},
    {1'b1, 4'hF, 32'h0000_0100, 32'h5555_5555},
    {1'b0, 4'hC, 32'h0000_0000, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int k = 0; k < 32; k++) mdl[k] = 8'((k * 37 + 5) % 256);
  endtask

  function automatic logic [31:0] mdl_word(input logic [31:0] o);
    logic [31:0] v = 0;
    for (int i = 0; i < 4; i++)
      if (o + i < 32) v[8*i +: 8] = mdl[o + i];
    return v;
  endfunction

  task automatic mdl_write(input logic [3:0] s, input logic [31:0] o, input logic [31:0] d);
    for (int i = 0; i < 4; i++)
      if (s[i] && o + i < 32) mdl[o + i] = d[8*i +: 8];
  endtask

  task automatic access(input logic w, input logic [3:0] s, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] r);
    int lat = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = w; sel = s; adr = a; wdat = d;
    while (lat < 20) begin
      @(posedge clk); #1; lat++;
      if (ack) break;
    end
    r = rdat;
    chk("R2 ack latency", 32'(lat), 32'd5);
    cyc = 0; stb = 0; we = 0;
    @(posedge clk); #1;
    chk("R3 ack single cycle", {31'd0, ack}, 32'd0);
  endtask

  task automatic watch_no_ack(input string tag, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (ack) seen++;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r;
    mdl_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R8 ack low in reset", {31'd0, ack}, 32'd0);
    @(negedge clk); rst = 0;

    // R8 reset contents, R4 lane order
    for (int w = 0; w < 8; w++) begin
      access(1'b0, 4'hF, BASE + 32'(4 * w), 32'h0, r);
      chk("R8 R4 reset value", r, mdl_word(32'(4 * w)));
    end

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][68], VEC[v][67:64], BASE + VEC[v][63:32], VEC[v][31:0], r);
      if (VEC[v][68]) mdl_write(VEC[v][67:64], VEC[v][63:32], VEC[v][31:0]);
      else chk("R4 R5 R6 R7 readback", r, mdl_word(VEC[v][63:32]));
    end

    // R1 addresses outside the window
    @(negedge clk); cyc = 1; stb = 1; we = 1; sel = 4'hF; adr = 32'h2700_0000; wdat = 32'h0;
    watch_no_ack("R1 above window", 10);
    @(negedge clk); adr = 32'h25FF_FFFC;
    watch_no_ack("R1 below window", 10);
    @(negedge clk); cyc = 0; stb = 0; we = 0;
    access(1'b0, 4'hF, BASE, 32'h0, r);
    chk("R1 no write outside", r, mdl_word(0));

    // R3 strobe without cycle, and idle after ack
    @(negedge clk); stb = 1; adr = BASE;
    watch_no_ack("R3 stb without cyc", 10);
    @(negedge clk); stb = 0;
    watch_no_ack("R3 stays idle", 10);

    // R8 reset in mid access
    @(negedge clk); cyc = 1; stb = 1; we = 1; sel = 4'hF; adr = BASE + 32'h10; wdat = 32'h9999_9999;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1; cyc = 0; stb = 0; we = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 0;
    watch_no_ack("R8 aborted no ack", 10);
    mdl_reset();
    access(1'b0, 4'hF, BASE + 32'h10, 32'h0, r);
    chk("R8 reset restores", r, mdl_word(32'h10));
    access(1'b0, 4'hF, BASE, 32'h0, r);
    chk("R8 reset restores low word", r, mdl_word(0));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule